// File: doc/BRIEF.md
# Quarter-step fractional-N feedback divider

This block is the programmable feedback divider of a frequency synthesizer loop. It counts cycles of its input clock, which is the already prescaled oscillator signal, and emits one single-cycle pulse per output period. A divide word holds an integer part N and a two-bit fraction k. Each period lasts either N or N+1 input cycles, and a small accumulator picks the long periods so that over four periods the mean ratio is N + k/4.

The divide word comes from a serial control path as a parallel word plus a strobe that marks the end of the bus transfer. The divider produces nothing until a first legal word has arrived. A new word is held as pending and is only switched in at the end of an output period that falls inside a window where the phase detector's charge pump is idle, so that a retune never cuts a period that is still driving the loop filter. A test bit routes the divided pulse to a monitor pin.

Top module: `qfrac_divider`

## Requirements
- R1: After reset, and until a first legal word has been loaded, `div_pulse` and `test_mon` stay low whatever the other inputs do.
- R2: The divide word splits as k = `cfg_word[1:0]` and N = `cfg_word[14:2]`. After a load the first period lasts N cycles; at every later period end a 2-bit accumulator adds k, and the period that follows lasts N+1 cycles when that addition carries out of the 2 bits and N cycles otherwise, so four periods total 4N+k cycles.
- R3: A strobed word whose value is below the minimum (parameter, default 2048) is discarded; the previous pending and active values stay in force.
- R4: `cfg_word` is only taken when `cfg_done` is high at a clock edge; changing the word without the strobe has no effect on the periods.
- R5: While running, a pending word is loaded only at the clock edge that ends a period (the edge at which `div_pulse` is high) and only if `pump_idle` is high at that edge; loading clears the accumulator. Otherwise the word stays pending and the old factor keeps running.
- R6: The first load happens at the first edge with a pending legal word and `pump_idle` high; the first `div_pulse` is then visible N cycles after that edge.
- R7: `test_mon` equals `div_pulse` when `test_en` is 1 and is 0 when `test_en` is 0.
- R8: `div_pulse` is high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided-input clock that the divider counts |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 15 | Divide word, 4N+k |
| cfg_done | input | 1 | Transfer-complete strobe, takes `cfg_word` |
| pump_idle | input | 1 | High while the charge pump is neither sourcing nor sinking |
| test_en | input | 1 | Routes the divided pulse to `test_mon` |
| div_pulse | output | 1 | One-cycle pulse at each period end |
| test_mon | output | 1 | Monitor copy of `div_pulse`, gated by `test_en` |

## Verification
The hardest situation to reach is a pending word that meets a pump-idle window lasting exactly one cycle: the word must go in if that cycle is a period end and must stay pending if it is not. The bench predicts every period end from its own arithmetic model, keeps `pump_idle` low, and raises it for a single cycle either mid-period or exactly on the predicted end cycle, then checks the following period lengths. A second stress is an exhaustive sweep over every legal word of a narrowed configuration, each loaded mid-run so the accumulator holds a non-zero value when it is cleared.

// File: rtl/qfd_pkg.sv
package qfd_pkg;
    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_RUN  = 1'b1
    } qfd_phase_e;

    localparam int unsigned QFD_INT_W_DFLT  = 13;
    localparam int unsigned QFD_FRAC_W_DFLT = 2;
    localparam int unsigned QFD_MIN_DFLT    = 2048;
endpackage

// File: rtl/qfd_cfg_hold.sv
module qfd_cfg_hold #(
    parameter int unsigned FACTOR_W   = 15,
    parameter int unsigned MIN_FACTOR = 2048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FACTOR_W-1:0] wr_word,
    input  logic                wr_done,
    input  logic                take,
    output logic                pend_valid,
    output logic [FACTOR_W-1:0] pend_word
);
    localparam logic [FACTOR_W-1:0] MIN_W = FACTOR_W'(MIN_FACTOR);

    typedef struct packed {
        logic                valid;
        logic [FACTOR_W-1:0] word;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.valid = 1'b0;
        end
        if (wr_done && (wr_word >= MIN_W)) begin
            hold_d.valid = 1'b1;
            hold_d.word  = wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign pend_valid = hold_q.valid;
    assign pend_word  = hold_q.word;
endmodule

// File: rtl/qfd_frac_acc.sv
module qfd_frac_acc #(
    parameter int unsigned FRAC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] k,
    output logic              carry
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_t;

    acc_t        acc_d, acc_q;
    logic [FRAC_W:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q.acc} + {1'b0, k};
        acc_d = acc_q;
        if (clear) begin
            acc_d.acc = '0;
        end else if (step) begin
            acc_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign carry = sum[FRAC_W];
endmodule

// File: rtl/qfd_period_cnt.sv
module qfd_period_cnt #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic             at_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload) begin
            cnt_d.cnt = reload_val;
        end else if (cnt_q.cnt != '0) begin
            cnt_d.cnt = cnt_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_end = (cnt_q.cnt == '0);
endmodule

// File: rtl/qfrac_divider.sv
module qfrac_divider
    import qfd_pkg::*;
#(
    parameter int unsigned INT_W      = QFD_INT_W_DFLT,
    parameter int unsigned FRAC_W     = QFD_FRAC_W_DFLT,
    parameter int unsigned MIN_FACTOR = QFD_MIN_DFLT,
    localparam int unsigned FACTOR_W  = INT_W + FRAC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FACTOR_W-1:0] cfg_word,
    input  logic                cfg_done,
    input  logic                pump_idle,
    input  logic                test_en,
    output logic                div_pulse,
    output logic                test_mon
);
    typedef struct packed {
        qfd_phase_e          phase;
        logic [FACTOR_W-1:0] factor;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                pend_valid;
    logic [FACTOR_W-1:0] pend_word;
    logic                take;
    logic                acc_clear;
    logic                acc_step;
    logic                carry;
    logic                cnt_end;
    logic                reload;
    logic [INT_W-1:0]    reload_val;
    logic                period_end;
    logic [INT_W-1:0]    n_cur;
    logic [INT_W-1:0]    n_new;
    logic [FRAC_W-1:0]   k_cur;
    logic                armed_q;
    logic [FACTOR_W-1:0] act_factor_q;

    assign armed_q      = (ctl_q.phase == PH_RUN);
    assign act_factor_q = ctl_q.factor;
    assign n_cur        = ctl_q.factor[FACTOR_W-1:FRAC_W];
    assign k_cur        = ctl_q.factor[FRAC_W-1:0];
    assign n_new        = pend_word[FACTOR_W-1:FRAC_W];
    assign period_end   = armed_q && cnt_end;

    always_comb begin
        ctl_d      = ctl_q;
        take       = pend_valid && pump_idle && (period_end || !armed_q);
        acc_clear  = 1'b0;
        acc_step   = 1'b0;
        reload     = 1'b0;
        reload_val = '0;
        if (take) begin
            ctl_d.phase  = PH_RUN;
            ctl_d.factor = pend_word;
            acc_clear    = 1'b1;
            reload       = 1'b1;
            reload_val   = n_new - INT_W'(1);
        end else if (period_end) begin
            acc_step   = 1'b1;
            reload     = 1'b1;
            reload_val = n_cur + INT_W'(carry) - INT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_WAIT, factor: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    qfd_cfg_hold #(
        .FACTOR_W  (FACTOR_W),
        .MIN_FACTOR(MIN_FACTOR)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_word   (cfg_word),
        .wr_done   (cfg_done),
        .take      (take),
        .pend_valid(pend_valid),
        .pend_word (pend_word)
    );

    qfd_frac_acc #(
        .FRAC_W(FRAC_W)
    ) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(acc_clear),
        .step (acc_step),
        .k    (k_cur),
        .carry(carry)
    );

    qfd_period_cnt #(
        .CNT_W(INT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload),
        .reload_val(reload_val),
        .at_end    (cnt_end)
    );

    assign div_pulse = period_end;
    assign test_mon  = test_en & period_end;
endmodule

// File: rtl/qfrac_divider_chk.sv
module qfrac_divider_chk #(
    parameter int unsigned FACTOR_W   = 15,
    parameter int unsigned MIN_FACTOR = 2048
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pump_idle,
    input logic                test_en,
    input logic                div_pulse,
    input logic                test_mon,
    input logic                armed,
    input logic [FACTOR_W-1:0] act_factor
);
    localparam logic [FACTOR_W-1:0] MIN_W = FACTOR_W'(MIN_FACTOR);

    AST_MON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> !test_mon); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R8

    AST_LOAD_AT_IDLE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed) && !$stable(act_factor)) |-> ($past(pump_idle) && $past(div_pulse))); // R5

    AST_FIRST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(pump_idle)); // R6

    AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (act_factor >= MIN_W)); // R3

    AST_NO_PULSE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(armed) |-> !test_mon); // R1
endmodule

bind qfrac_divider qfrac_divider_chk #(
    .FACTOR_W  (FACTOR_W),
    .MIN_FACTOR(MIN_FACTOR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pump_idle (pump_idle),
    .test_en   (test_en),
    .div_pulse (div_pulse),
    .test_mon  (test_mon),
    .armed     (armed_q),
    .act_factor(act_factor_q)
);

// File: tb/test_qfrac_divider.sv
module test_qfrac_divider;
    localparam int INT_W  = 6;
    localparam int FRAC_W = 2;
    localparam int FW     = INT_W + FRAC_W;
    localparam int MINF   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] cfg_word = '0;
    logic          cfg_done = 1'b0;
    logic          pump_idle = 1'b0;
    logic          test_en = 1'b0;
    logic          div_pulse;
    logic          test_mon;

    int checks = 0;
    int fails = 0;
    int mon_bad = 0;
    int mon_hits = 0;
    int wide = 0;
    bit finished = 1'b0;
    int m_n = 0, m_k = 0, m_acc = 0;

    always #4 clk = ~clk;

    qfrac_divider #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_FACTOR(MINF)
    ) i_qfrac_divider (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_done(cfg_done),
        .pump_idle(pump_idle), .test_en(test_en),
        .div_pulse(div_pulse), .test_mon(test_mon)
    );

    function automatic int step_model();
        int s = m_acc + m_k;
        int g = m_n + ((s >= 4) ? 1 : 0);
        m_acc = s % 4;
        return g;
    endfunction

    function automatic int load_model(int f);
        m_n = f / 4;
        m_k = f % 4;
        m_acc = 0;
        return m_n;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // idle_at: -1 keeps pump_idle high, otherwise high only during that cycle index
    task automatic next_pulse(input int idle_at, output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            cfg_done = 1'b0;
            if (test_mon !== (test_en & div_pulse)) mon_bad++;
            if (test_mon) mon_hits++;
            if (div_pulse && gap == 1) wide++;
            if (!div_pulse) pump_idle = (idle_at < 0) ? 1'b1 : (gap == idle_at);
        end while (!div_pulse && gap < 5000);
    endtask

    task automatic count_quiet(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_done = 1'b0;
            if (div_pulse || test_mon) pulses++;
        end
    endtask

    task automatic run_gaps(input int n, input int idle_at, input string req);
        int g, e, bad_a, bad_e;
        bit ok = 1'b1;
        bad_a = 0; bad_e = 0;
        for (int i = 0; i < n; i++) begin
            e = step_model();
            next_pulse(idle_at, g);
            if (g != e && ok) begin ok = 1'b0; bad_a = g; bad_e = e; end
        end
        check(ok, req, bad_a, bad_e);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int q, g, e;
        bit ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        test_en = 1'b1;
        pump_idle = 1'b1;
        check(div_pulse === 1'b0 && test_mon === 1'b0, "R1 reset state", div_pulse, 0);

        // R1: unprogrammed, pump idle, no pulses
        count_quiet(100, q);
        check(q == 0, "R1 unprogrammed", q, 0);

        // R3: sub-minimum word while waiting does not start the divider
        cfg_word = FW'(10); cfg_done = 1'b1;
        count_quiet(100, q);
        check(q == 0, "R3 reject while waiting", q, 0);

        // R6: legal word, pump busy: stays quiet
        pump_idle = 1'b0;
        cfg_word = FW'(41); cfg_done = 1'b1;
        count_quiet(100, q);
        check(q == 0, "R6 wait for idle", q, 0);
        pump_idle = 1'b1;
        e = load_model(41);
        next_pulse(-1, g);
        check(g == e, "R6 first pulse delay", g, e);

        run_gaps(8, -1, "R2 k=1 pattern");

        // R4: word change without strobe
        cfg_word = FW'(200);
        run_gaps(6, -1, "R4 no strobe");

        // R3: sub-minimum word while running
        cfg_word = FW'(15); cfg_done = 1'b1;
        run_gaps(6, -1, "R3 reject while running");

        // R2 / R5: exhaustive sweep of legal words, loaded mid-run
        for (int f = MINF; f < (1 << FW); f++) begin
            int ba, be;
            ok = 1'b1; ba = 0; be = 0;
            cfg_word = FW'(f); cfg_done = 1'b1;
            e = step_model();
            next_pulse(-1, g);
            if (g != e) begin ok = 1'b0; ba = g; be = e; end
            e = load_model(f);
            next_pulse(-1, g);
            if (g != e && ok) begin ok = 1'b0; ba = g; be = e; end
            for (int i = 0; i < 4; i++) begin
                e = step_model();
                next_pulse(-1, g);
                if (g != e && ok) begin ok = 1'b0; ba = g; be = e; end
            end
            if (f % 16 == 0 || !ok) check(ok, "R2 sweep", ba, be);
        end

        // R5: pump busy keeps old factor
        cfg_word = FW'(40); cfg_done = 1'b1;
        e = step_model();
        next_pulse(-1, g);
        e = load_model(40);
        next_pulse(-1, g);
        check(g == e, "R2 reload 40", g, e);
        pump_idle = 1'b0;
        cfg_word = FW'(31); cfg_done = 1'b1;
        run_gaps(5, 0, "R5 busy keeps old");

        // R5: one idle cycle inside a period does not load
        run_gaps(2, 3, "R5 mid-period idle");

        // R5: one idle cycle exactly at a period end loads
        pump_idle = 1'b1;
        e = load_model(31);
        next_pulse(0, g);
        check(g == e, "R5 idle at period end", g, e);
        run_gaps(4, 0, "R5 new factor k=3");

        // R7: monitor gated off
        test_en = 1'b0;
        q = mon_hits;
        run_gaps(4, -1, "R7 test off periods");
        check(mon_hits == q, "R7 monitor quiet", mon_hits - q, 0);
        test_en = 1'b1;
        run_gaps(2, -1, "R7 test on periods");
        check(mon_bad == 0 && mon_hits > q, "R7 monitor follows", mon_bad, 0);

        check(wide == 0, "R8 single-cycle pulse", wide, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule